// File: doc/BRIEF.md
# CCD Sensor Drive Timing Generator

This block derives every logic-level drive pulse for an interlaced monochrome CCD area sensor from one pixel-rate clock. A pixel counter runs across a line of 618 clocks, and a line counter runs across the frame. From these two counters the block decodes the following outputs:

- the four vertical transfer phases;
- the transfer-gate readout pulse;
- the overflow-drain shutter pulse;
- the enables for the horizontal and reset clocks;
- a flag that marks the active pixel span;
- the line and field sync strobes.

The frame holds two interlaced fields. Each vertical sync line toggles a field flag. The field flag selects which line carries the readout pulse.

A mode input selects normal or mirror readout. In mirror mode every pulse edge inside the line moves 20 clocks earlier. Mirror mode also sends the horizontal clock enable to the alternate pair of horizontal clocks, which reverses the pixel order. The mode is sampled only when a frame begins.

Electronic shuttering is controlled by a stop-line input. It gives the number of lines, counted from the start of the field, that carry an overflow-drain pulse. Zero turns shuttering off.

Top module: `ccd_drive_gen`

## Requirements
- R1: While `rst` is high and in the cycle after it, `hpos` and `vline` are 0. While `rst` is high, `v1`, `v2`, `v4`, `tg`, `ofd`, `hd`, `vd`, `hfwd_en`, `hrev_en`, `rs_en` and `pix_act` are 0, and `v3` is 1. The field flag clears to 0 and the captured mode clears to normal.
- R2: The counters behave as follows:
  - `hpos` counts 0 to LINE_LEN-1 and then wraps to 0.
  - `vline` advances when `hpos` wraps, and wraps to 0 after FRAME_LINES-1.
  - `hd` is 1 exactly while `hpos` < 16.
- R3: In normal mode, the vertical phases decode from `hpos` as follows (a window [a,b) means a ≤ hpos < b):
  - `v1` is 1 over [29,49).
  - `v2` is 1 over [39,59).
  - `v4` is 1 over [34,64).
  - `v3` is 0 over [24,54) and 1 elsewhere.
- R4: In mirror mode, every `hpos` window in R3, R7, R8 and R9 starts and ends 20 counts earlier.
- R5: `mirror_in` is captured only on the clock edge where `hpos` wraps on line FRAME_LINES-1. A change at any other time has no effect until the next frame begins.
- R6: `vd` is 1 for the whole of lines RD_A's partner VD_A_LINE and VD_B_LINE. `field` toggles on entry to each of those lines.
- R7: `tg` is 1 over [242,338), a 96-clock window, on line RD_A_LINE when `field` is 0 and on line RD_B_LINE when `field` is 1. It is 0 on every other line.
- R8: The field-line index restarts at 0 on each vertical sync line and otherwise advances by one per line. `ofd` is 1 over [62,72) on lines whose field-line index is below `shut_stop`. `ofd` is never 1 when `shut_stop` is 0.
- R9: `rs_en` is 1 over [70,616), a 546-clock window. In normal mode `hfwd_en` equals `rs_en`, and in mirror mode `hrev_en` equals `rs_en`. The two are never 1 together. `pix_act` is 1 over [76,588), which is the 512 pixels that follow 4 prescan clocks and 2 black clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| mirror_in | input | 1 | 1 selects mirror readout from the next frame |
| shut_stop | input | VW | Field lines carrying shutter pulses; 0 disables shuttering |
| hpos | output | HW | Pixel position in the line |
| vline | output | VW | Line number in the frame |
| hd | output | 1 | Line sync |
| vd | output | 1 | Field sync |
| field | output | 1 | Field flag |
| v1 | output | 1 | Vertical phase 1 |
| v2 | output | 1 | Vertical phase 2 |
| v3 | output | 1 | Vertical phase 3 (low-active window) |
| v4 | output | 1 | Vertical phase 4 |
| tg | output | 1 | Transfer-gate readout pulse |
| ofd | output | 1 | Overflow-drain shutter pulse |
| hfwd_en | output | 1 | Enable for the normal horizontal clock pair |
| hrev_en | output | 1 | Enable for the alternate horizontal clock pair |
| rs_en | output | 1 | Reset clock enable |
| pix_act | output | 1 | Active pixel span |

## Verification
The bench compares every output in every cycle against a frame model that is kept from the requirements.

It targets several corner cases:
- **Mode change in mid-frame.** A design that used the mode at once would shift its vertical edges by 20 counts in the middle of a field.
- **Alternating readout line.** A design that ignored the field flag would pulse the transfer gate on both candidate lines, or on the wrong one.
- **Shutter stop line.** A design that compared the stop line with the frame line instead of the field line would stop the pulse train at the wrong line in the second field. A design with an off-by-one would emit one pulse too many or too few per field.
- **Reset in mid-line.** A design that left pulses ungated would show live phases while held in reset.

// File: rtl/ccd_drive_gen.sv
module ccd_drive_gen #(
  parameter int LINE_LEN    = 618,
  parameter int FRAME_LINES = 625,
  parameter int VD_A_LINE   = 622,
  parameter int RD_A_LINE   = 19,
  parameter int VD_B_LINE   = 310,
  parameter int RD_B_LINE   = 331,
  localparam int HW = $clog2(LINE_LEN),
  localparam int VW = $clog2(FRAME_LINES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mirror_in,
  input  logic [VW-1:0] shut_stop,
  output logic [HW-1:0] hpos,
  output logic [VW-1:0] vline,
  output logic          hd,
  output logic          vd,
  output logic          field,
  output logic          v1,
  output logic          v2,
  output logic          v3,
  output logic          v4,
  output logic          tg,
  output logic          ofd,
  output logic          hfwd_en,
  output logic          hrev_en,
  output logic          rs_en,
  output logic          pix_act
);

  localparam logic [HW-1:0] HLAST = HW'(LINE_LEN - 1);
  localparam logic [VW-1:0] VLAST = VW'(FRAME_LINES - 1);
  localparam logic [VW-1:0] VDA   = VW'(VD_A_LINE);
  localparam logic [VW-1:0] VDB   = VW'(VD_B_LINE);
  localparam logic [VW-1:0] RDA   = VW'(RD_A_LINE);
  localparam logic [VW-1:0] RDB   = VW'(RD_B_LINE);
  localparam logic [HW-1:0] SHIFT = HW'(20);

  logic [VW-1:0] fline;
  logic          mir_q;
  logic [VW-1:0] vnext;
  logic          run;

  assign run   = !rst;
  assign vnext = (vline == VLAST) ? '0 : vline + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      hpos  <= '0;
      vline <= '0;
      field <= 1'b0;
      fline <= '0;
      mir_q <= 1'b0;
    end else if (hpos == HLAST) begin
      hpos  <= '0;
      vline <= vnext;
      if (vline == VLAST) mir_q <= mirror_in;
      if (vnext == VDA || vnext == VDB) begin
        field <= !field;
        fline <= '0;
      end else begin
        fline <= fline + 1'b1;
      end
    end else begin
      hpos <= hpos + 1'b1;
    end
  end

  function automatic logic in_win(input logic [HW-1:0] p, input int lo, input int hi,
                                  input logic m);
    logic [HW-1:0] l, h;
    l = m ? HW'(lo) - SHIFT : HW'(lo);
    h = m ? HW'(hi) - SHIFT : HW'(hi);
    return (p >= l) && (p < h);
  endfunction

  logic rd_line, h_win;
  assign rd_line = field ? (vline == RDB) : (vline == RDA);
  assign h_win   = in_win(hpos, 70, 616, mir_q);

  assign hd      = run && (hpos < HW'(16));
  assign vd      = run && (vline == VDA || vline == VDB);
  assign v1      = run && in_win(hpos, 29, 49, mir_q);
  assign v2      = run && in_win(hpos, 39, 59, mir_q);
  assign v3      = rst || !in_win(hpos, 24, 54, mir_q);
  assign v4      = run && in_win(hpos, 34, 64, mir_q);
  assign tg      = run && rd_line && in_win(hpos, 242, 338, mir_q);
  assign ofd     = run && (shut_stop != '0) && (fline < shut_stop) &&
                   in_win(hpos, 62, 72, mir_q);
  assign rs_en   = run && h_win;
  assign hfwd_en = run && h_win && !mir_q;
  assign hrev_en = run && h_win && mir_q;
  assign pix_act = run && in_win(hpos, 76, 588, mir_q);

  // R2
  hwrap_chk: assert property (@(posedge clk) disable iff (rst)
    hpos == HLAST |=> hpos == '0);

  // R5
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(hpos == '0 && vline == '0) |-> $stable(mir_q));

  // R6
  field_flip_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(vd) |-> field != $past(field));

  // R7
  tg_line_chk: assert property (@(posedge clk) disable iff (rst)
    tg |-> ((vline == RDA && !field) || (vline == RDB && field)));

  // R8
  ofd_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ofd |-> (shut_stop != '0 && fline < shut_stop));

  // R9
  hpair_chk: assert property (@(posedge clk) disable iff (rst)
    !(hfwd_en && hrev_en));

  // R3
  v_order_chk: assert property (@(posedge clk) disable iff (rst)
    v1 |-> !v3);

endmodule

// File: tb/ccd_drive_gen_tb.sv
module ccd_drive_gen_tb;
  localparam int LL = 618, FL = 30, VDA = 29, RDA = 3, VDB = 14, RDB = 18;
  localparam int HW = $clog2(LL), VW = $clog2(FL);

  logic clk = 0, rst = 1, mirror_in = 0;
  logic [VW-1:0] shut_stop = '0;
  logic [HW-1:0] hpos;
  logic [VW-1:0] vline;
  logic hd, vd, field, v1, v2, v3, v4, tg, ofd, hfwd_en, hrev_en, rs_en, pix_act;

  int checks = 0, fails = 0;
  int ofd_cnt = 0, tg_cnt = 0;
  bit chk_on = 0;

  always #2.5 clk = ~clk;

  ccd_drive_gen #(.LINE_LEN(LL), .FRAME_LINES(FL), .VD_A_LINE(VDA), .RD_A_LINE(RDA),
                  .VD_B_LINE(VDB), .RD_B_LINE(RDB)) u_dut (
    .clk(clk), .rst(rst), .mirror_in(mirror_in), .shut_stop(shut_stop),
    .hpos(hpos), .vline(vline), .hd(hd), .vd(vd), .field(field),
    .v1(v1), .v2(v2), .v3(v3), .v4(v4), .tg(tg), .ofd(ofd),
    .hfwd_en(hfwd_en), .hrev_en(hrev_en), .rs_en(rs_en), .pix_act(pix_act));

  int m_h = 0, m_v = 0, m_fl = 0;
  bit m_fld = 0, m_mir = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_h <= 0; m_v <= 0; m_fl <= 0; m_fld <= 0; m_mir <= 0;
    end else if (m_h == LL - 1) begin
      int nv;
      nv = (m_v == FL - 1) ? 0 : m_v + 1;
      m_h <= 0;
      m_v <= nv;
      if (m_v == FL - 1) m_mir <= mirror_in;
      if (nv == VDA || nv == VDB) begin m_fld <= !m_fld; m_fl <= 0; end
      else m_fl <= m_fl + 1;
    end else m_h <= m_h + 1;
  end

  function automatic bit w(int p, int lo, int hi, bit m);
    int o;
    o = m ? 20 : 0;
    return p >= lo - o && p < hi - o;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s at line %0d pos %0d: actual %0d expected %0d", req, what, m_v, m_h, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      string rv;
      bit e_tg, e_ofd, e_win, e_v3;
      rv = m_mir ? "R4" : "R3";
      e_v3 = rst ? 1'b1 : !w(m_h, 24, 54, m_mir);
      e_tg = !rst && ((m_fld ? m_v == RDB : m_v == RDA) && w(m_h, 242, 338, m_mir));
      e_ofd = !rst && shut_stop != 0 && m_fl < int'(shut_stop) && w(m_h, 62, 72, m_mir);
      e_win = !rst && w(m_h, 70, 616, m_mir);
      chk(int'(hpos) == m_h && int'(vline) == m_v, "R2", "counters", int'(hpos), m_h);
      chk(hd == (!rst && m_h < 16), "R2", "hd", hd, !rst && m_h < 16);
      chk(v1 == (!rst && w(m_h, 29, 49, m_mir)), rv, "v1", v1, !rst && w(m_h, 29, 49, m_mir));
      chk(v2 == (!rst && w(m_h, 39, 59, m_mir)), rv, "v2", v2, !rst && w(m_h, 39, 59, m_mir));
      chk(v3 == e_v3, rv, "v3", v3, e_v3);
      chk(v4 == (!rst && w(m_h, 34, 64, m_mir)), rv, "v4", v4, !rst && w(m_h, 34, 64, m_mir));
      chk(vd == (!rst && (m_v == VDA || m_v == VDB)), "R6", "vd", vd, !rst && (m_v == VDA || m_v == VDB));
      chk(field == m_fld, "R6", "field", field, m_fld);
      chk(tg == e_tg, "R7", "tg", tg, e_tg);
      chk(ofd == e_ofd, "R8", "ofd", ofd, e_ofd);
      chk(rs_en == e_win, "R9", "rs_en", rs_en, e_win);
      chk(hfwd_en == (e_win && !m_mir) && hrev_en == (e_win && m_mir), "R9", "hpair",
          {hfwd_en, hrev_en}, {e_win && !m_mir, e_win && m_mir});
      chk(pix_act == (!rst && w(m_h, 76, 588, m_mir)), "R9", "pix_act", pix_act,
          !rst && w(m_h, 76, 588, m_mir));
      if (ofd) ofd_cnt++;
      if (tg) tg_cnt++;
    end
  end

  task automatic run_lines(input int n);
    repeat (n * LL) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1; chk_on = 1;
    repeat (3) @(negedge clk);
    chk(hpos == 0 && vline == 0, "R1", "reset counters", int'(hpos), 0);
    chk(!v1 && !v2 && v3 && !v4 && !tg && !ofd && !hd && !vd && !rs_en && !pix_act, "R1",
        "reset pulses", {v1, v2, v3, v4, tg, ofd}, 6'b001000);
    rst = 0;
  endtask

  task automatic t_normal_frame();
    shut_stop = '0; mirror_in = 0; ofd_cnt = 0; tg_cnt = 0;
    run_lines(FL);
    chk(ofd_cnt == 0, "R8", "ofd count with stop 0", ofd_cnt, 0);
    chk(tg_cnt == 96 * 2, "R7", "tg clocks per frame", tg_cnt, 192);
  endtask

  task automatic t_shutter();
    @(negedge clk); shut_stop = VW'(4); ofd_cnt = 0;
    run_lines(FL);
    chk(ofd_cnt == 4 * 10 * 2, "R8", "ofd clocks per frame, stop 4", ofd_cnt, 80);
    shut_stop = '0;
  endtask

  task automatic t_mode_switch();
    while (!(hpos == 10 && vline == 5)) @(negedge clk);
    mirror_in = 1;
    run_lines(2);
    chk(v1 == 0 && hfwd_en == 0, "R5", "mode ignored mid-frame", v1, 0);
    while (!(hpos == 30 && vline == 8)) @(negedge clk);
    chk(v1 == 1, "R5", "still normal v1 at 30", v1, 1);
    while (!(hpos == 100 && vline == 1)) @(negedge clk);
    chk(hrev_en == 1 && hfwd_en == 0, "R4", "mirror pair after frame start", hrev_en, 1);
    tg_cnt = 0; shut_stop = VW'(3); ofd_cnt = 0;
    run_lines(FL);
    chk(tg_cnt == 192, "R4", "mirror tg clocks", tg_cnt, 192);
    chk(ofd_cnt == 60, "R4", "mirror ofd clocks", ofd_cnt, 60);
    shut_stop = '0;
  endtask

  task automatic t_mid_reset();
    while (hpos != 40) @(negedge clk);
    rst = 1;
    @(negedge clk);
    chk(v1 == 0 && v3 == 1 && hd == 0, "R1", "pulses idle in reset", v1, 0);
    @(negedge clk); rst = 0;
    @(negedge clk);
    chk(hpos == 1 && vline == 0, "R1", "counters restart", int'(hpos), 1);
    run_lines(3);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_normal_frame();
        t_shutter();
        t_mode_switch();
        mirror_in = 0;
        t_mid_reset();
      end
      begin
        repeat (190000) @(negedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    chk_on = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule